// File: doc/BRIEF.md
# Memory-Mapped Test Traffic Generator

This block generates synthetic transfer requests for exercising a host link. Software fills in a 64-bit target address, a burst count, a starting data pattern and a control word through a 32-bit register port. It then sets the start bit of the control word. The engine issues fixed-length requests on a valid/ready request port. It stops after the programmed number of requests, or keeps going while the repeat bit of the burst register stays set. The engine can hold the address fixed or advance it by the request size. The data pattern can stay constant or advance by one per data word.

Two 64-bit tallies count the data words of accepted requests, one tally for each direction. Software can freeze both tallies so that their low and high words form a consistent snapshot. Packet formation, the physical link and return data are handled by neighbouring blocks.

Top module: `trafgen_engine`

## Requirements
- R1: After reset every register reads as zero and `req_valid` is low.
- R2: A read of an offset not listed in the map returns zero, a misaligned offset counts as unlisted, and writes to such offsets change no register. Map (byte offsets): 0x000 address low, 0x004 address high, 0x008 burst, 0x00C control, 0x010 pattern, 0x014 status, 0x018 and 0x01C scratch words, 0x058 tally control, 0x100/0x104 write tally low/high, 0x108/0x10C read tally low/high. A read returns its data one cycle after `reg_rd_en`, with `reg_rvalid`.
- R3: Writing the control word with bit 0 set starts generation when the engine is idle. Bit 0 always reads back as zero. Control bit 1 selects the direction (1 = write), and it appears on `req_is_write`. The other stored control bits (13:2, 16, 18) read back as written.
- R4: Every request carries the length held in control bits 13:2 (in 32-bit words) on `req_len_dw`.
- R5: With burst bit 31 clear, exactly burst[30:0] requests are accepted. After that `req_valid` drops and status bit 0 becomes 1. A count of zero sets status bit 0 without issuing any request.
- R6: The first request uses the {high, low} address. Each accepted request adds 4 × length to the address, with 64-bit wrap. Control bit 18 set keeps the address fixed.
- R7: The first request's `req_data` equals the pattern register. With control bit 16 set, each following request's data is larger by the length (one per data word), modulo 2^32. Otherwise the data stays constant.
- R8: While burst bit 31 is set, a new burst of burst[30:0] requests follows each completed one (a count of zero counts as one). Clearing bit 31 ends generation when the current burst completes.
- R9: Writing the status register with bit 0 clear clears status bit 0. Starting a new run also clears it.
- R10: A start request made while requests are in progress is ignored. Direction, length and address of the running stream stay unchanged.
- R11: Each accepted request adds its length to the 64-bit tally of its direction.
- R12: Tally control bit 5 enables counting. While it is clear, both tallies hold their value.
- R13: While `req_valid` is high and `req_ready` is low, all request fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd_en |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the consumer |
| req_is_write | output | 1 | Request direction, 1 = write |
| req_addr | output | 64 | Request target address |
| req_len_dw | output | 12 | Request length in 32-bit words |
| req_data | output | 32 | Pattern value of the first data word |

## Verification
A start write sampled at a clock edge raises `req_valid` at that same edge. Each request accepted at an edge shows its successor, or drops `req_valid`, at that edge. Status bit 0 is set one edge later than the last acceptance, and a register read presents its data one edge after the strobe. The bench therefore drives `req_ready` on the falling edge and judges a handshake from values settled just after it. Before it reads the status register, it lets two edges pass after the final request.

// File: rtl/trafgen_pkg.sv
package trafgen_pkg;

  localparam int LEN_W   = 12;
  localparam int CNT_BITS = 31;

  // word indices (byte offset >> 2)
  localparam logic [9:0] IX_ADDR_LO = 10'h000;
  localparam logic [9:0] IX_ADDR_HI = 10'h001;
  localparam logic [9:0] IX_BURST   = 10'h002;
  localparam logic [9:0] IX_CTRL    = 10'h003;
  localparam logic [9:0] IX_PATTERN = 10'h004;
  localparam logic [9:0] IX_STATUS  = 10'h005;
  localparam logic [9:0] IX_SCR0    = 10'h006;
  localparam logic [9:0] IX_SCR1    = 10'h007;
  localparam logic [9:0] IX_TALLYC  = 10'h016;
  localparam logic [9:0] IX_WR_LO   = 10'h040;
  localparam logic [9:0] IX_WR_HI   = 10'h041;
  localparam logic [9:0] IX_RD_LO   = 10'h042;
  localparam logic [9:0] IX_RD_HI   = 10'h043;

  localparam int          BIT_START   = 0;
  localparam int          BIT_DIR     = 1;
  localparam int          BIT_PAT_INC = 16;
  localparam int          BIT_FIXADDR = 18;
  localparam int          BIT_REPEAT  = 31;
  localparam int          BIT_TALLY   = 5;
  localparam logic [31:0] CTRL_KEEP   = 32'h0005_3FFE;

  typedef struct packed {
    logic             is_write;
    logic [LEN_W-1:0] len;
    logic             pat_inc;
    logic             addr_fixed;
  } job_cfg_t;

  function automatic job_cfg_t unpack_ctrl(input logic [31:0] w);
    job_cfg_t c;
    c.is_write   = w[BIT_DIR];
    c.len        = w[LEN_W+1:2];
    c.pat_inc    = w[BIT_PAT_INC];
    c.addr_fixed = w[BIT_FIXADDR];
    return c;
  endfunction

endpackage

// File: rtl/trafgen_regs.sv
module trafgen_regs
  import trafgen_pkg::*;
#(
  parameter int AW    = 12,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  output logic             rvalid,
  input  logic             busy,
  input  logic             done_pulse,
  input  logic [CNT_W-1:0] wr_total,
  input  logic [CNT_W-1:0] rd_total,
  output logic             ring,
  output job_cfg_t         ring_cfg,
  output logic [63:0]      base_addr,
  output logic [31:0]      burst_word,
  output logic [31:0]      pattern,
  output logic             tally_on
);

  localparam int IXW = AW - 2;

  logic [31:0] addr_lo_q, addr_hi_q, burst_q, ctrl_q, pat_q, scr0_q, scr1_q;
  logic        done_q, tally_q;
  logic [IXW-1:0] ix;
  logic        aligned;
  logic [31:0] rd_mux;
  logic [63:0] wr64, rd64;

  assign ix      = addr[AW-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign wr64    = 64'(wr_total);
  assign rd64    = 64'(rd_total);

  function automatic logic hit(input logic [IXW-1:0] i, input logic al,
                               input logic [9:0] target);
    return al && (i == IXW'(target));
  endfunction

  assign ring     = wr_en && hit(ix, aligned, IX_CTRL) && wdata[BIT_START];
  assign ring_cfg = unpack_ctrl(wdata);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_lo_q <= '0;
      addr_hi_q <= '0;
      burst_q   <= '0;
      ctrl_q    <= '0;
      pat_q     <= '0;
      scr0_q    <= '0;
      scr1_q    <= '0;
      tally_q   <= 1'b0;
    end else if (wr_en && aligned) begin
      if (hit(ix, aligned, IX_ADDR_LO)) addr_lo_q <= wdata;
      if (hit(ix, aligned, IX_ADDR_HI)) addr_hi_q <= wdata;
      if (hit(ix, aligned, IX_BURST))   burst_q   <= wdata;
      if (hit(ix, aligned, IX_CTRL))    ctrl_q    <= wdata & CTRL_KEEP;
      if (hit(ix, aligned, IX_PATTERN)) pat_q     <= wdata;
      if (hit(ix, aligned, IX_SCR0))    scr0_q    <= wdata;
      if (hit(ix, aligned, IX_SCR1))    scr1_q    <= wdata;
      if (hit(ix, aligned, IX_TALLYC))  tally_q   <= wdata[BIT_TALLY];
    end
  end

  // done flag: set by the sequencer, cleared by status write or accepted start
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else if (done_pulse) begin
      done_q <= 1'b1;
    end else if ((ring && !busy) ||
                 (wr_en && hit(ix, aligned, IX_STATUS) && !wdata[0])) begin
      done_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      unique case (ix)
        IXW'(IX_ADDR_LO): rd_mux = addr_lo_q;
        IXW'(IX_ADDR_HI): rd_mux = addr_hi_q;
        IXW'(IX_BURST):   rd_mux = burst_q;
        IXW'(IX_CTRL):    rd_mux = ctrl_q;
        IXW'(IX_PATTERN): rd_mux = pat_q;
        IXW'(IX_STATUS):  rd_mux = {31'd0, done_q};
        IXW'(IX_SCR0):    rd_mux = scr0_q;
        IXW'(IX_SCR1):    rd_mux = scr1_q;
        IXW'(IX_TALLYC):  rd_mux = 32'(tally_q) << BIT_TALLY;
        IXW'(IX_WR_LO):   rd_mux = wr64[31:0];
        IXW'(IX_WR_HI):   rd_mux = wr64[63:32];
        IXW'(IX_RD_LO):   rd_mux = rd64[31:0];
        IXW'(IX_RD_HI):   rd_mux = rd64[63:32];
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign base_addr  = {addr_hi_q, addr_lo_q};
  assign burst_word = burst_q;
  assign pattern    = pat_q;
  assign tally_on   = tally_q;

endmodule

// File: rtl/trafgen_seq.sv
module trafgen_seq
  import trafgen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ring,
  input  job_cfg_t          ring_cfg,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [31:0]       burst_word,
  input  logic [DATA_W-1:0] pattern,
  input  logic              req_ready,
  output logic              req_valid,
  output logic              req_is_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len_dw,
  output logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done_pulse
);

  typedef enum logic {S_IDLE, S_RUN} seq_state_t;

  seq_state_t          state;
  logic [CNT_BITS-1:0] remaining;
  logic                inc_q, fix_q;
  logic [CNT_BITS-1:0] count_field;
  logic                repeat_on;

  assign count_field = burst_word[CNT_BITS-1:0];
  assign repeat_on   = burst_word[BIT_REPEAT];

  function automatic logic [CNT_BITS-1:0] reload(input logic [CNT_BITS-1:0] c);
    return (c == '0) ? CNT_BITS'(1) : c;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      remaining    <= '0;
      req_addr     <= '0;
      req_data     <= '0;
      req_len_dw   <= '0;
      req_is_write <= 1'b0;
      inc_q        <= 1'b0;
      fix_q        <= 1'b0;
      done_pulse   <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (ring) begin
            req_addr     <= base_addr;
            req_data     <= pattern;
            req_len_dw   <= ring_cfg.len;
            req_is_write <= ring_cfg.is_write;
            inc_q        <= ring_cfg.pat_inc;
            fix_q        <= ring_cfg.addr_fixed;
            if (!repeat_on && count_field == '0) begin
              done_pulse <= 1'b1;
            end else begin
              state     <= S_RUN;
              remaining <= reload(count_field);
            end
          end
        end
        S_RUN: begin
          if (req_ready) begin
            if (!fix_q) req_addr <= req_addr + (ADDR_W'(req_len_dw) << 2);
            if (inc_q)  req_data <= req_data + DATA_W'(req_len_dw);
            if (remaining == CNT_BITS'(1)) begin
              if (repeat_on) begin
                remaining <= reload(count_field);
              end else begin
                state      <= S_IDLE;
                done_pulse <= 1'b1;
              end
            end else begin
              remaining <= remaining - CNT_BITS'(1);
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (state == S_RUN);
  assign busy      = (state == S_RUN);

endmodule

// File: rtl/trafgen_tally.sv
module trafgen_tally #(
  parameter int CNT_W = 64,
  parameter int AMT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             bump,
  input  logic [AMT_W-1:0] amount,
  output logic [CNT_W-1:0] total
);

  always_ff @(posedge clk) begin
    if (rst) begin
      total <= '0;
    end else if (enable && bump) begin
      total <= total + CNT_W'(amount);
    end
  end

endmodule

// File: rtl/trafgen_engine.sv
module trafgen_engine
  import trafgen_pkg::*;
#(
  parameter int AW     = 12,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_is_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len_dw,
  output logic [DATA_W-1:0] req_data
);

  localparam int NDIR = 2;  // index 0 = write, 1 = read

  logic        db_ring, busy, done_pulse, tally_on, fire;
  job_cfg_t    ring_cfg;
  logic [63:0] base_addr;
  logic [31:0] burst_word, pattern;
  logic [CNT_W-1:0] totals [NDIR];
  logic [CNT_W-1:0] wr_total, rd_total;

  trafgen_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .rvalid(reg_rvalid),
    .busy(busy), .done_pulse(done_pulse),
    .wr_total(wr_total), .rd_total(rd_total),
    .ring(db_ring), .ring_cfg(ring_cfg), .base_addr(base_addr),
    .burst_word(burst_word), .pattern(pattern), .tally_on(tally_on)
  );

  trafgen_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .ring(db_ring), .ring_cfg(ring_cfg),
    .base_addr(ADDR_W'(base_addr)), .burst_word(burst_word),
    .pattern(DATA_W'(pattern)), .req_ready(req_ready),
    .req_valid(req_valid), .req_is_write(req_is_write), .req_addr(req_addr),
    .req_len_dw(req_len_dw), .req_data(req_data),
    .busy(busy), .done_pulse(done_pulse)
  );

  assign fire = req_valid && req_ready;

  for (genvar d = 0; d < NDIR; d++) begin : g_tally
    trafgen_tally #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_tally (
      .clk(clk), .rst(rst),
      .enable(tally_on),
      .bump(fire && (req_is_write == (d == 0))),
      .amount(req_len_dw),
      .total(totals[d])
    );
  end

  assign wr_total = totals[0];
  assign rd_total = totals[1];

endmodule

// File: rtl/trafgen_engine_chk.sv
module trafgen_engine_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              db_ring,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [11:0]       req_len_dw,
  input logic [DATA_W-1:0] req_data,
  input logic              tally_on,
  input logic [CNT_W-1:0]  wr_total,
  input logic [CNT_W-1:0]  rd_total
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !req_valid);

  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid) |-> $past(db_ring));

  // R5
  stop_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(req_valid) |-> $past(req_ready));

  // R13
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_data) && $stable(req_is_write) && $stable(req_len_dw)));

  // R12
  frozen_tally_chk: assert property (@(posedge clk) disable iff (rst)
    !tally_on |=> ($stable(wr_total) && $stable(rd_total)));

endmodule

bind trafgen_engine trafgen_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .db_ring(db_ring),
  .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
  .req_addr(req_addr), .req_len_dw(req_len_dw), .req_data(req_data),
  .tally_on(tally_on), .wr_total(wr_total), .rd_total(rd_total)
);

// File: tb/trafgen_engine_test.sv
`timescale 1ns/1ps
module trafgen_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        req_valid, req_is_write;
  logic        req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [11:0] req_len_dw;
  logic [31:0] req_data;

  int errors = 0;
  int checks = 0;
  logic [63:0] exp_wr = '0, exp_rd = '0;
  logic        tally_en = 1'b0;

  always #5 clk = ~clk;

  trafgen_engine uut (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_write(req_is_write),
    .req_addr(req_addr), .req_len_dw(req_len_dw), .req_data(req_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
    if (!reg_rvalid) begin
      errors++; checks++;
      $display("FAIL R2 read valid actual=0 expected=1");
    end
  endtask

  function automatic logic [31:0] ctrl_word(input bit w, input logic [11:0] len,
                                            input bit inc, input bit fix);
    return 32'h1 | (32'(w) << 1) | (32'(len) << 2) | (32'(inc) << 16) | (32'(fix) << 18);
  endfunction

  function automatic logic [63:0] exp_addr(input logic [63:0] b, input int k,
                                           input logic [11:0] len, input bit fix);
    return fix ? b : b + 64'(k) * (64'(len) << 2);
  endfunction

  function automatic logic [31:0] exp_data(input logic [31:0] p, input int k,
                                           input logic [11:0] len, input bit inc);
    return inc ? p + 32'(k) * 32'(len) : p;
  endfunction

  task automatic check_tallies();
    logic [31:0] lo, hi;
    reg_read(12'h100, lo); reg_read(12'h104, hi);
    check("R11 write tally", {hi, lo}, exp_wr);
    reg_read(12'h108, lo); reg_read(12'h10C, hi);
    check("R11 read tally", {hi, lo}, exp_rd);
  endtask

  // program and run one finite job, checking every accepted request
  task automatic run_job(input bit w, input logic [11:0] len, input int cnt,
                         input logic [63:0] base, input logic [31:0] pat,
                         input bit inc, input bit fix);
    logic [31:0] st;
    int k = 0;
    int guard = 0;
    req_ready = 1'b0;
    reg_write(12'h000, base[31:0]);
    reg_write(12'h004, base[63:32]);
    reg_write(12'h008, 32'(cnt));
    reg_write(12'h010, pat);
    reg_write(12'h00C, ctrl_word(w, len, inc, fix));
    while (k < cnt && guard < 4000) begin
      @(negedge clk);
      req_ready = ($urandom % 4) != 0;
      #1;
      if (req_valid && req_ready) begin
        check("R3 direction", 64'(req_is_write), 64'(w));
        check("R4 length", 64'(req_len_dw), 64'(len));
        check("R6 address", req_addr, exp_addr(base, k, len, fix));
        check("R7 pattern", 64'(req_data), 64'(exp_data(pat, k, len, inc)));
        if (tally_en) begin
          if (w) exp_wr += 64'(len); else exp_rd += 64'(len);
        end
        k++;
      end
      guard++;
    end
    check("R5 request count", 64'(k), 64'(cnt));
    @(negedge clk);
    req_ready = 1'b1;
    #1;
    check("R5 valid low after last", 64'(req_valid), 64'd0);
    @(negedge clk); @(negedge clk);
    req_ready = 1'b0;
    reg_read(12'h014, st);
    check("R5 done set", 64'(st), 64'd1);
    reg_write(12'h014, 32'h0);
    reg_read(12'h014, st);
    check("R9 done cleared", 64'(st), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [63:0] b0, a_hold;
    logic [11:0] off [13];
    int hs;
    void'($urandom(32'd20240611));
    off = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h014, 12'h018,
            12'h01C, 12'h058, 12'h100, 12'h104, 12'h108, 12'h10C};
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    #1 check("R1 valid after reset", 64'(req_valid), 64'd0);
    foreach (off[i]) begin
      reg_read(off[i], rv);
      check("R1 register reset", 64'(rv), 64'd0);
    end

    // R2 unlisted offsets
    reg_write(12'h020, 32'hDEADBEEF);
    reg_read(12'h020, rv);  check("R2 unlisted write", 64'(rv), 64'd0);
    reg_read(12'h1F0, rv);  check("R2 unlisted read", 64'(rv), 64'd0);
    reg_write(12'h012, 32'h1234_5678);
    reg_read(12'h010, rv);  check("R2 misaligned write", 64'(rv), 64'd0);
    reg_write(12'h018, 32'hA5A5_0001);
    reg_read(12'h018, rv);  check("R2 scratch word", 64'(rv), 64'hA5A5_0001);

    // enable tallies (R12)
    reg_write(12'h058, 32'h20);
    tally_en = 1'b1;
    reg_read(12'h058, rv);  check("R12 tally enable readback", 64'(rv), 64'h20);

    // directed cases
    run_job(1'b1, 12'd4, 3, 64'h0000_0001_0000_1000, 32'h10, 1'b1, 1'b0);
    reg_read(12'h00C, rv);
    check("R3 control readback", 64'(rv), 64'(ctrl_word(1'b1, 12'd4, 1'b1, 1'b0) & 32'hFFFF_FFFE));
    run_job(1'b0, 12'd8, 4, 64'h0000_0000_2000_0000, 32'hFFFF_FFF0, 1'b1, 1'b1);
    run_job(1'b1, 12'd1, 3, 64'hFFFF_FFFF_FFFF_FFF8, 32'h7, 1'b0, 1'b0);
    run_job(1'b0, 12'd2, 0, 64'h40, 32'h0, 1'b0, 1'b0);
    check_tallies();

    // random jobs
    for (int j = 0; j < 12; j++) begin
      run_job(1'($urandom), 12'(1 + $urandom % 16), int'($urandom % 7),
              {$urandom, $urandom}, $urandom, 1'($urandom), 1'($urandom));
    end
    check_tallies();

    // R12 freeze
    reg_write(12'h058, 32'h0);
    tally_en = 1'b0;
    run_job(1'b1, 12'd5, 2, 64'h800, 32'h0, 1'b0, 1'b0);
    run_job(1'b0, 12'd5, 2, 64'h800, 32'h0, 1'b0, 1'b0);
    check_tallies();
    reg_write(12'h058, 32'h20);
    tally_en = 1'b1;

    // R8 repeat, R10 ignored start while busy
    b0 = 64'h0000_0000_0001_0000;
    req_ready = 1'b0;
    reg_write(12'h000, b0[31:0]);
    reg_write(12'h004, b0[63:32]);
    reg_write(12'h008, 32'h8000_0002);
    reg_write(12'h010, 32'h100);
    reg_write(12'h00C, ctrl_word(1'b1, 12'd3, 1'b1, 1'b0));
    hs = 0;
    while (hs < 7) begin
      @(negedge clk);
      req_ready = 1'b1;
      #1;
      if (req_valid) begin
        check("R8 repeat address", req_addr, exp_addr(b0, hs, 12'd3, 1'b0));
        exp_wr += 64'd3;
        hs++;
      end
    end
    @(negedge clk);
    req_ready = 1'b0;
    #1 a_hold = req_addr;
    reg_write(12'h00C, ctrl_word(1'b0, 12'd9, 1'b0, 1'b1));
    #1;
    check("R10 direction kept", 64'(req_is_write), 64'd1);
    check("R10 length kept", 64'(req_len_dw), 64'd3);
    check("R10 address kept", req_addr, a_hold);
    check("R8 still running past count", 64'(req_valid), 64'd1);
    reg_write(12'h008, 32'h0000_0002);
    for (int g = 0; g < 20; g++) begin
      @(negedge clk);
      req_ready = 1'b1;
      #1;
      if (req_valid) begin
        check("R8 trailing address", req_addr, exp_addr(b0, hs, 12'd3, 1'b0));
        check("R7 trailing pattern", 64'(req_data), 64'(exp_data(32'h100, hs, 12'd3, 1'b1)));
        exp_wr += 64'd3;
        hs++;
      end
    end
    check("R8 stops at burst end", 64'(hs), 64'd8);
    req_ready = 1'b0;
    reg_read(12'h014, rv);
    check("R8 done after repeat", 64'(rv), 64'd1);
    check_tallies();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule